// File: doc/BRIEF.md
# Configurable Eight-Pin I/O Port with Dual-Edge Interrupts

This block is an eight-pin general-purpose I/O port that sits between a simple register bus and a set of tristate pads. Each pin takes its behaviour from four bits that belong to it: a level bit, a direction bit and two selector bits. Together these bits pick one of several drive styles. A pin can be a driven output, a floating input, a pin that only sinks current, a pin that only sources current, a parked high-impedance pin, or an input that raises an interrupt on every change of level.

Pad levels pass through a two-flop synchroniser before the block uses them. A bus read of the level address returns the synchronised pad state and never the stored level bit. In interrupt mode, each rising or falling edge of a pin sets that pin's pending flag. Software clears a flag by writing a 1 to its bit at the clear address. All pending flags are ORed onto one interrupt line.

Top module: `mgpio_port`

## Requirements
- R1: After reset, every level bit is 0, every direction bit is 1 and both selector bits are 0. All pad enables are therefore low, no flag is pending, and a read of address 1 returns 0xFF.
- R2: With {sel2, sel1, dir} = 000 the pin is a driven output: pad_oe is 1 and pad_out equals the level bit.
- R3: With {sel2, sel1, dir} = 001 the pin is an input: pad_oe is 0 whatever the level bit holds.
- R4: With {sel2, sel1, dir} = 010 the pin is open-drain: a level bit of 0 gives pad_oe=1 with pad_out=0, and a level bit of 1 gives pad_oe=0.
- R5: With {sel2, sel1, dir} = 011 the pin is open-source: a level bit of 1 gives pad_oe=1 with pad_out=1, and a level bit of 0 gives pad_oe=0.
- R6: With {sel2, sel1, dir} = 100 and a level bit of 0 (the parked mode), pad_oe is 0. The codes 101, 110 and 111 act as input, also with pad_oe=0.
- R7: A read of address 0 returns the pad level as sampled by two flops. A pad change made before clock edge k is visible after edge k+1.
- R8: Addresses 0 to 3 are written as level, direction, sel1 and sel2. Addresses 1 to 3 read back the stored value, address 4 reads the pending flags, and addresses 5 to 7 read 0.
- R9: With {sel2, sel1, dir} = 100 and a level bit of 1 (dual-edge mode), a rising or falling pad change made before edge k sets the pin's flag after edge k+2. Pad changes in any other mode set no flag.
- R10: Writing to address 4 clears each flag whose bit in the written value is 1, and leaves each flag whose bit is 0 unchanged.
- R11: If a new edge is detected on a pin in the same cycle that a clear write targets that pin, the flag stays set.
- R12: irq is 1 exactly when at least one flag is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 3 | Register address for both writes and reads |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pad_in | input | 8 | Pad levels (asynchronous) |
| pad_out | output | 8 | Value sent to each pad driver |
| pad_oe | output | 8 | Driver enable for each pad |
| irq_flags | output | 8 | Pending interrupt flag for each pin |
| irq | output | 1 | OR of all pending flags |

## Verification
Flag setting and flag clearing can land in the same cycle, and both act on the same flag. The bench provokes this by changing a pad of a pin in dual-edge mode. It then times a clear write so that the write is sampled on exactly the edge where the synchronised level and its delayed copy differ. The result is judged twice. First, the bench's behavioural model gives priority to the edge and is compared with the outputs every cycle. Second, a directed check reads the flags back after that edge and expects the bit to still be set.

// File: rtl/mgpio_pkg.sv
package mgpio_pkg;

  typedef enum logic [2:0] {
    PM_OUT,
    PM_IN,
    PM_ODRAIN,
    PM_OSRC,
    PM_PARK,
    PM_EDGE
  } pin_mode_e;

  localparam int ADR_LVL  = 0;
  localparam int ADR_DIR  = 1;
  localparam int ADR_SEL1 = 2;
  localparam int ADR_SEL2 = 3;
  localparam int ADR_CLR  = 4;

  // Mode selection from the four per-pin bits.
  function automatic pin_mode_e decode_mode(logic lvl, logic dir, logic s1, logic s2);
    pin_mode_e m;
    case ({s2, s1, dir})
      3'b000:  m = PM_OUT;
      3'b001:  m = PM_IN;
      3'b010:  m = PM_ODRAIN;
      3'b011:  m = PM_OSRC;
      3'b100:  m = lvl ? PM_EDGE : PM_PARK;
      default: m = PM_IN;
    endcase
    return m;
  endfunction

  // Returns {enable, value} for the pad driver.
  function automatic logic [1:0] drive_of(pin_mode_e m, logic lvl);
    logic [1:0] r;
    case (m)
      PM_OUT:    r = {1'b1, lvl};
      PM_ODRAIN: r = {~lvl, 1'b0};
      PM_OSRC:   r = {lvl, 1'b1};
      default:   r = 2'b00;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mgpio_sync.sv
module mgpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
    end
  end

  assign sync_out = sync_q;
endmodule

// File: rtl/mgpio_pin_ctrl.sv
module mgpio_pin_ctrl
  import mgpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] lvl_bits,
  input  logic [W-1:0] dir_bits,
  input  logic [W-1:0] sel1_bits,
  input  logic [W-1:0] sel2_bits,
  output logic [W-1:0] drv_val,
  output logic [W-1:0] drv_en,
  output logic [W-1:0] edge_mode
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    pin_mode_e  mode_w;
    logic [1:0] drv_w;
    assign mode_w       = decode_mode(lvl_bits[i], dir_bits[i], sel1_bits[i], sel2_bits[i]);
    assign drv_w        = drive_of(mode_w, lvl_bits[i]);
    assign drv_en[i]    = drv_w[1];
    assign drv_val[i]   = drv_w[0];
    assign edge_mode[i] = (mode_w == PM_EDGE);
  end
endmodule

// File: rtl/mgpio_irq.sv
module mgpio_irq #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sync_lvl,
  input  logic [W-1:0] edge_mode,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] edge_ev,
  output logic [W-1:0] pend
);
  logic [W-1:0] prev_q;
  logic [W-1:0] pend_q;

  assign edge_ev = sync_lvl ^ prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= sync_lvl;
      // a fresh edge outranks a clear in the same cycle
      pend_q <= (edge_ev & edge_mode) | (pend_q & ~clr_mask);
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/mgpio_port.sv
module mgpio_port
  import mgpio_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_oe,
  output logic [W-1:0]  irq_flags,
  output logic          irq
);
  logic [W-1:0] lvl_q, dir_q, sel1_q, sel2_q;
  logic [W-1:0] sync_lvl;
  logic [W-1:0] edge_mode;
  logic [W-1:0] edge_ev;
  logic [W-1:0] clr_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      dir_q  <= '1;
      sel1_q <= '0;
      sel2_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == AW'(ADR_LVL))  lvl_q  <= bus_wdata;
      if (bus_addr == AW'(ADR_DIR))  dir_q  <= bus_wdata;
      if (bus_addr == AW'(ADR_SEL1)) sel1_q <= bus_wdata;
      if (bus_addr == AW'(ADR_SEL2)) sel2_q <= bus_wdata;
    end
  end

  assign clr_mask = (bus_wr && bus_addr == AW'(ADR_CLR)) ? bus_wdata : '0;

  always_comb begin
    bus_rdata = '0;
    if      (bus_addr == AW'(ADR_LVL))  bus_rdata = sync_lvl;
    else if (bus_addr == AW'(ADR_DIR))  bus_rdata = dir_q;
    else if (bus_addr == AW'(ADR_SEL1)) bus_rdata = sel1_q;
    else if (bus_addr == AW'(ADR_SEL2)) bus_rdata = sel2_q;
    else if (bus_addr == AW'(ADR_CLR))  bus_rdata = irq_flags;
  end

  mgpio_sync #(.W(W)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (sync_lvl)
  );

  mgpio_pin_ctrl #(.W(W)) u_pins (
    .lvl_bits  (lvl_q),
    .dir_bits  (dir_q),
    .sel1_bits (sel1_q),
    .sel2_bits (sel2_q),
    .drv_val   (pad_out),
    .drv_en    (pad_oe),
    .edge_mode (edge_mode)
  );

  mgpio_irq #(.W(W)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_lvl  (sync_lvl),
    .edge_mode (edge_mode),
    .clr_mask  (clr_mask),
    .edge_ev   (edge_ev),
    .pend      (irq_flags)
  );

  assign irq = |irq_flags;
endmodule

// File: rtl/mgpio_port_chk.sv
module mgpio_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] lvl_q,
  input logic [W-1:0] dir_q,
  input logic [W-1:0] sel1_q,
  input logic [W-1:0] sel2_q,
  input logic [W-1:0] pad_out,
  input logic [W-1:0] pad_oe,
  input logic [W-1:0] irq_flags,
  input logic [W-1:0] edge_ev,
  input logic [W-1:0] edge_mode,
  input logic [W-1:0] clr_mask
);
  logic [W-1:0] m_pp, m_in, m_od;
  assign m_pp = ~sel2_q & ~sel1_q & ~dir_q;
  assign m_in = ~sel2_q & ~sel1_q &  dir_q;
  assign m_od = ~sel2_q &  sel1_q & ~dir_q;

  // R2
  push_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~pad_oe & m_pp) == '0) && (((pad_out ^ lvl_q) & m_pp) == '0));

  // R3
  input_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & m_in) == '0);

  // R4
  open_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & m_od) == (~lvl_q & m_od)) && ((pad_out & pad_oe & m_od) == '0));

  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flags & ~$past(irq_flags) & ~$past(edge_ev & edge_mode)) == '0);

  // R10
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flags & $past(clr_mask & ~(edge_ev & edge_mode))) == '0);

  // R11
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr_mask & edge_ev & edge_mode) & ~irq_flags) == '0);
endmodule

bind mgpio_port mgpio_port_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lvl_q     (lvl_q),
  .dir_q     (dir_q),
  .sel1_q    (sel1_q),
  .sel2_q    (sel2_q),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .irq_flags (irq_flags),
  .edge_ev   (edge_ev),
  .edge_mode (edge_mode),
  .clr_mask  (clr_mask)
);

// File: tb/mgpio_port_tb.sv
module mgpio_port_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in = 8'd0;
  logic [7:0] pad_out, pad_oe, irq_flags;
  logic       irq;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  mgpio_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_flags(irq_flags), .irq(irq)
  );

  // behavioural reference model
  byte unsigned m_lvl = 0, m_dir = 8'hFF, m_s1 = 0, m_s2 = 0, m_flag = 0;
  byte unsigned hist[$] = '{0, 0, 0, 0};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lvl = 0; m_dir = 8'hFF; m_s1 = 0; m_s2 = 0; m_flag = 0;
      hist = '{0, 0, 0, 0};
    end else begin
      for (int i = 0; i < 8; i++) begin
        bit irqm, chg, clr;
        irqm = m_s2[i] && !m_s1[i] && !m_dir[i] && m_lvl[i];
        chg  = hist[1][i] != hist[2][i];
        clr  = bus_wr && bus_addr == 3'd4 && bus_wdata[i];
        if (irqm && chg) m_flag[i] = 1'b1;
        else if (clr)    m_flag[i] = 1'b0;
      end
      if (bus_wr) begin
        case (bus_addr)
          3'd0: m_lvl = bus_wdata;
          3'd1: m_dir = bus_wdata;
          3'd2: m_s1  = bus_wdata;
          3'd3: m_s2  = bus_wdata;
          default: ;
        endcase
      end
      hist.push_front(pad_in);
      void'(hist.pop_back());
    end
  end

  function automatic logic [15:0] exp_pads();
    logic [7:0] oe = 0, o = 0;
    for (int i = 0; i < 8; i++) begin
      case ({m_s2[i], m_s1[i], m_dir[i]})
        3'b000: begin oe[i] = 1'b1; o[i] = m_lvl[i]; end
        3'b010: begin oe[i] = !m_lvl[i]; o[i] = 1'b0; end
        3'b011: begin oe[i] = m_lvl[i]; o[i] = 1'b1; end
        default: ;
      endcase
    end
    return {oe, o};
  endfunction

  function automatic logic [7:0] exp_rd(logic [2:0] a);
    case (a)
      3'd0: return hist[1];
      3'd1: return m_dir;
      3'd2: return m_s1;
      3'd3: return m_s2;
      3'd4: return m_flag;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h at t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      logic [15:0] e;
      e = exp_pads();
      check("R2 R3 R4 R5 R6 pad_oe", pad_oe, e[15:8]);
      check("R2 R4 R5 pad_out (enabled bits)", pad_out & pad_oe, e[7:0] & e[15:8]);
      check("R7 R8 bus_rdata", bus_rdata, exp_rd(bus_addr));
      check("R9 R10 R11 irq_flags", irq_flags, m_flag);
      check("R12 irq", {7'd0, irq}, {7'd0, m_flag != 0});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(string tag, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk); #1;
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic set_pad(input logic [7:0] v);
    @(negedge clk); #1;
    pad_in = v;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    idle(3);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd_chk("R1 dir after reset", 3'd1, 8'hFF);
    check("R1 pad_oe after reset", pad_oe, 8'h00);
    check("R1 irq after reset", {7'd0, irq}, 8'h00);
    rd_chk("R1 sel2 after reset", 3'd3, 8'h00);

    // R2 push-pull output
    wr(3'd0, 8'hA5); wr(3'd1, 8'h00); idle(1);
    check("R2 pad_oe", pad_oe, 8'hFF);
    check("R2 pad_out", pad_out, 8'hA5);
    rd_chk("R8 dir readback", 3'd1, 8'h00);

    // R3 input: level bit has no effect
    wr(3'd1, 8'hFF); wr(3'd0, 8'h3C); idle(1);
    check("R3 pad_oe with data changed", pad_oe, 8'h00);

    // R4 open-drain
    wr(3'd2, 8'hFF); wr(3'd1, 8'h00); wr(3'd0, 8'h0F); idle(1);
    check("R4 pad_oe", pad_oe, 8'hF0);
    check("R4 pad_out enabled", pad_out & pad_oe, 8'h00);

    // R5 open-source
    wr(3'd1, 8'hFF); idle(1);
    check("R5 pad_oe", pad_oe, 8'h0F);
    check("R5 pad_out enabled", pad_out & pad_oe, 8'h0F);
    rd_chk("R8 sel1 readback", 3'd2, 8'hFF);

    // R6 parked and undefined codes
    wr(3'd3, 8'hFF); idle(1);
    check("R6 codes 111 pad_oe", pad_oe, 8'h00);
    wr(3'd1, 8'h00); idle(1);
    check("R6 code 110 pad_oe", pad_oe, 8'h00);
    wr(3'd2, 8'h00); wr(3'd0, 8'h00); idle(1);
    check("R6 parked pad_oe", pad_oe, 8'h00);
    rd_chk("R8 unused address", 3'd6, 8'h00);

    // R7 pad level readback latency
    bus_addr = 3'd0;
    set_pad(8'h5A);
    @(negedge clk); #1; check("R7 level not yet visible", bus_rdata, 8'h00);
    @(negedge clk); #1; check("R7 level visible", bus_rdata, 8'h5A);
    set_pad(8'h00); idle(3);

    // R9 dual-edge on low nibble, parked upper nibble
    wr(3'd0, 8'h0F); idle(1);
    check("R9 edge-mode pads released", pad_oe, 8'h00);
    set_pad(8'h81); idle(4);
    check("R9 rising edge sets flag 0 only", irq_flags, 8'h01);
    set_pad(8'h80); idle(4);
    check("R9 falling edge keeps flag 0", irq_flags, 8'h01);
    set_pad(8'h84); idle(4);
    check("R9 second pin flagged", irq_flags, 8'h05);
    check("R12 irq set", {7'd0, irq}, 8'h01);

    // R10 clear with mask
    wr(3'd4, 8'h01); idle(1);
    check("R10 flag 0 cleared, flag 2 kept", irq_flags, 8'h04);
    wr(3'd4, 8'h00); idle(1);
    check("R10 zero write keeps flags", irq_flags, 8'h04);

    // R11 edge coincides with clear of the same pin
    set_pad(8'h86);
    @(negedge clk); @(negedge clk); #1;
    bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 8'h02;
    @(negedge clk); #1;
    bus_wr = 1'b0;
    check("R11 edge wins over clear", irq_flags & 8'h02, 8'h02);

    wr(3'd4, 8'hFF); idle(1);
    check("R12 irq low once all cleared", {7'd0, irq}, 8'h00);
    // R9 edges outside dual-edge mode are ignored
    wr(3'd1, 8'hFF); set_pad(8'h00); idle(4);
    check("R9 no flag in input mode", irq_flags, 8'h00);
    idle(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end
endmodule